// File: doc/BRIEF.md
# Register Write-Protection Unlock Controller

This block keeps a small bank of critical configuration registers, such as clock or PLL settings, safe from stray writes. It sits on a simple register bus with address, write data, write enable, read enable and read data. It holds one guard register.

Software opens the bank by writing three fixed key words to the guard register, one after another. It closes the bank again by writing zero to the guard register. The block drives a registered `unlocked_o` flag. The local protected bank uses this flag to gate its writes, and other register files can use it for their own protected fields.

A read of the guard register returns the current lock state, so a driver can repeat the key sequence until the readback is nonzero. Each read answers one cycle after its read enable.

Top module: `wp_unlock_ctrl`

## Requirements
- R1: After a synchronous reset the block is locked (`unlocked_o` = 0), the key detector is idle and every protected register holds 0.
- R2: A read of the guard register (address 0) returns 0 while locked and 1 while unlocked. Read data for any address appears on `bus_rdata` in the cycle after `bus_re` is sampled.
- R3: A write of the value 0 to the guard register locks the block.
- R4: While locked, a write to a protected register (addresses 4 to 7) is dropped and the register keeps its value. Reads of protected registers work in both states.
- R5: While locked, three writes to the guard register with the values 0x59, 0x16 and 0x88, in that order, unlock the block.
- R6: `unlocked_o` rises on the clock edge that accepts the 0x88 write, so a protected write in the very next bus cycle takes effect.
- R7: While unlocked, a write of any nonzero value to the guard register leaves the block unlocked.
- R8: A guard-register write that does not match the expected next key word returns the detector to idle. If that word is 0x59, it counts as the first word of a new attempt.
- R9: Writes to addresses other than the guard register neither advance nor reset the key detector.
- R10: Reads of addresses that map to neither the guard register nor a protected register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after `bus_re` |
| unlocked_o | output | 1 | High while protected registers may be written |

## Verification
The bench attacks the detector with broken sequences. These include a wrong middle word, a stray 0x59 that must restart the attempt, and key words out of order. A detector that fails to restart on 0x59, or that keeps partial progress after a mismatch, would unlock on the wrong sequence or miss the right one.

It interleaves protected and unmapped writes between key words. A design that let those writes reset or advance the detector would break a valid unlock, and a bank that ignored the gate would change its contents.

It places a protected write in the cycle right after the last key word. An extra register stage on the unlock flag would drop that write.

It writes nonzero non-key values while unlocked. A design that relocked on anything but zero would drop later protected writes.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_GOT1 = 2'd1,
    KS_GOT2 = 2'd2
  } kseq_e;
endpackage

// File: rtl/wp_key_fsm.sv
module wp_key_fsm #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY0 = 'h59,
  parameter logic [DATA_W-1:0] KEY1 = 'h16,
  parameter logic [DATA_W-1:0] KEY2 = 'h88
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              guard_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked_q
);
  import wp_pkg::*;

  kseq_e st_q, st_n;
  logic  unl_n;

  always_comb begin
    st_n  = st_q;
    unl_n = unlocked_q;
    if (guard_wr) begin
      if (unlocked_q) begin
        st_n = KS_IDLE;
        if (wdata == '0) unl_n = 1'b0;
      end else begin
        unique case (st_q)
          KS_IDLE: st_n = (wdata == KEY0) ? KS_GOT1 : KS_IDLE;
          KS_GOT1: begin
            if (wdata == KEY1)      st_n = KS_GOT2;
            else if (wdata == KEY0) st_n = KS_GOT1;
            else                    st_n = KS_IDLE;
          end
          KS_GOT2: begin
            if (wdata == KEY2) begin
              st_n  = KS_IDLE;
              unl_n = 1'b1;
            end else if (wdata == KEY0) begin
              st_n = KS_GOT1;
            end else begin
              st_n = KS_IDLE;
            end
          end
          default: st_n = KS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= KS_IDLE;
      unlocked_q <= 1'b0;
    end else begin
      st_q       <= st_n;
      unlocked_q <= unl_n;
    end
  end
endmodule

// File: rtl/wp_prot_bank.sv
module wp_prot_bank #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_PROT  = 4,
  parameter int PROT_BASE = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       unlocked,
  output logic [NUM_PROT*DATA_W-1:0] regs_flat
);
  for (genvar i = 0; i < NUM_PROT; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] RADDR = ADDR_W'(PROT_BASE + i);
    logic [DATA_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst)                                 val_q <= '0;
      else if (we && unlocked && addr == RADDR) val_q <= wdata;
    end
    assign regs_flat[i*DATA_W +: DATA_W] = val_q;
  end
endmodule

// File: rtl/wp_rd_path.sv
module wp_rd_path #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_PROT  = 4,
  parameter int PROT_BASE = 4,
  parameter int GUARD_ADR = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       re,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       unlocked,
  input  logic [NUM_PROT*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]          rdata
);
  logic [DATA_W-1:0] rd_n;

  always_comb begin
    rd_n = '0;
    if (addr == ADDR_W'(GUARD_ADR)) rd_n = {{(DATA_W-1){1'b0}}, unlocked};
    for (int i = 0; i < NUM_PROT; i++) begin
      if (addr == ADDR_W'(PROT_BASE + i)) rd_n = regs_flat[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_n;
  end
endmodule

// File: rtl/wp_unlock_ctrl.sv
module wp_unlock_ctrl #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_PROT  = 4,
  parameter int PROT_BASE = 4,
  parameter int GUARD_ADR = 0,
  parameter logic [DATA_W-1:0] KEY0 = 'h59,
  parameter logic [DATA_W-1:0] KEY1 = 'h16,
  parameter logic [DATA_W-1:0] KEY2 = 'h88
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              unlocked_o
);
  localparam int BANK_W = NUM_PROT * DATA_W;

  logic              guard_wr;
  logic [BANK_W-1:0] prot_flat;

  assign guard_wr = bus_we && (bus_addr == ADDR_W'(GUARD_ADR));

  wp_key_fsm #(.DATA_W(DATA_W), .KEY0(KEY0), .KEY1(KEY1), .KEY2(KEY2)) u_fsm (
    .clk(clk), .rst(rst), .guard_wr(guard_wr), .wdata(bus_wdata),
    .unlocked_q(unlocked_o)
  );

  wp_prot_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT),
                 .PROT_BASE(PROT_BASE)) u_bank (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .unlocked(unlocked_o), .regs_flat(prot_flat)
  );

  wp_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT),
               .PROT_BASE(PROT_BASE), .GUARD_ADR(GUARD_ADR)) u_rd (
    .clk(clk), .rst(rst), .re(bus_re), .addr(bus_addr), .unlocked(unlocked_o),
    .regs_flat(prot_flat), .rdata(bus_rdata)
  );
endmodule

// File: rtl/wp_unlock_chk.sv
module wp_unlock_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_PROT  = 4,
  parameter int GUARD_ADR = 0,
  parameter logic [DATA_W-1:0] KEY2 = 'h88
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic                       bus_we,
  input logic                       bus_re,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic                       unlocked_o,
  input logic [NUM_PROT*DATA_W-1:0] prot_flat
);
  // R1
  reset_locks_chk: assert property (@(posedge clk) rst |=> !unlocked_o);

  // R5
  unlock_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked_o) |-> $past(bus_we && bus_addr == ADDR_W'(GUARD_ADR) && bus_wdata == KEY2));

  // R3
  relock_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(unlocked_o) |-> ($past(rst) ||
      $past(bus_we && bus_addr == ADDR_W'(GUARD_ADR) && bus_wdata == '0)));

  // R4
  bank_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !unlocked_o |=> $stable(prot_flat));

  // R2
  guard_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == ADDR_W'(GUARD_ADR)) |=> ((bus_rdata != '0) == $past(unlocked_o)));
endmodule

bind wp_unlock_ctrl wp_unlock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT),
  .GUARD_ADR(GUARD_ADR), .KEY2(KEY2)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .unlocked_o(unlocked_o), .prot_flat(prot_flat)
);

// File: tb/sim_wp_unlock_ctrl.sv
module sim_wp_unlock_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 32;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          unlocked_o;
  logic          re_d = 1'b0;

  int    n_run = 0;
  int    n_fail = 0;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_unlock_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .unlocked_o(unlocked_o)
  );

  always @(posedge clk) re_d <= bus_re;

  always @(negedge clk) begin
    if (re_d) begin
      item_t it;
      n_run++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic chk_unl(input logic e, input string tag);
    n_run++;
    if (unlocked_o !== e) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, unlocked_o, e);
    end
  endtask

  task automatic key_seq();
    wr(4'd0, 32'h59); wr(4'd0, 32'h16); wr(4'd0, 32'h88);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_unl(1'b0, "R1 locked after reset");
    rd(4'd0, 32'd0, "R1/R2 guard reads 0 after reset");
    rd(4'd5, 32'd0, "R1 protected reg reset value");
    // R4 locked write dropped
    wr(4'd4, 32'h1234);
    rd(4'd4, 32'd0, "R4 locked write dropped");
    // R5/R6 unlock and back-to-back protected write
    key_seq();
    chk_unl(1'b1, "R5 unlocked after key");
    wr(4'd4, 32'hCAFE);
    rd(4'd4, 32'hCAFE, "R6 write in cycle after final key");
    rd(4'd0, 32'd1, "R2 guard reads 1 when unlocked");
    // R7 nonzero keeps unlocked
    wr(4'd0, 32'h16);
    wr(4'd0, 32'hFFFF_0000);
    chk_unl(1'b1, "R7 nonzero keeps unlocked");
    wr(4'd7, 32'h77);
    rd(4'd7, 32'h77, "R7 protected write still accepted");
    // R3 relock
    wr(4'd0, 32'h0);
    chk_unl(1'b0, "R3 relock on zero");
    wr(4'd4, 32'hDEAD);
    rd(4'd4, 32'hCAFE, "R3/R4 write dropped after relock, read allowed");
    // R8 wrong middle word then retry
    wr(4'd0, 32'h59); wr(4'd0, 32'h17); wr(4'd0, 32'h88);
    chk_unl(1'b0, "R8 wrong middle word stays locked");
    wr(4'd0, 32'h16); wr(4'd0, 32'h88);
    chk_unl(1'b0, "R8 partial tail after mismatch stays locked");
    // R8 stray 0x59 restarts
    wr(4'd0, 32'h59); wr(4'd0, 32'h59); wr(4'd0, 32'h16); wr(4'd0, 32'h88);
    chk_unl(1'b1, "R8 repeated first word restarts attempt");
    wr(4'd0, 32'h0);
    wr(4'd0, 32'h59); wr(4'd0, 32'h16); wr(4'd0, 32'h59); wr(4'd0, 32'h16);
    wr(4'd0, 32'h88);
    chk_unl(1'b1, "R8 first word at third step restarts attempt");
    wr(4'd0, 32'h0);
    // R5 order matters
    wr(4'd0, 32'h88); wr(4'd0, 32'h16); wr(4'd0, 32'h59);
    chk_unl(1'b0, "R5 reversed order stays locked");
    wr(4'd0, 32'h0);
    // R9 interleaved other writes
    wr(4'd0, 32'h59);
    wr(4'd5, 32'h55);
    wr(4'd0, 32'h16);
    wr(4'd12, 32'h0);
    wr(4'd2, 32'h88);
    wr(4'd0, 32'h88);
    chk_unl(1'b1, "R9 other-address writes do not break sequence");
    rd(4'd5, 32'd0, "R9/R4 protected write between keys dropped");
    // R10 unmapped reads
    rd(4'd2, 32'd0, "R10 unmapped read zero");
    rd(4'd12, 32'd0, "R10 unmapped read zero high");
    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_unl(1'b0, "R1 locked after mid-run reset");
    rd(4'd4, 32'd0, "R1 bank cleared by reset");
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 reads unanswered actual=%0d expected=0", sb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule